// File: doc/BRIEF.md
# Condition-Field Predicate Reduction Unit

This execution unit carries out a pair of predication instructions that share one major opcode. It owns a 32-bit condition register split into eight 4-bit fields. The direction flag in the instruction word picks one of two behaviours.

In the gather direction, the unit compares each bit of one selected field against its own mode polarity. It gates each comparison with a mask bit and ORs the four results into a single 0/1 value. That value goes back to an integer register through a write-back port.

In the scatter direction, the unit takes the least significant bit of an integer operand and compares it against each mode bit under the mask. It then writes the four results into the selected field and leaves every other field alone. The integer operand comes from an external register file, which reads at the index that the unit decodes. All effects appear one clock after a valid instruction is presented.

Top module: `cr_pred_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `cr_q` is zero and both `wb_en` and `illegal` are low.
- R2: An instruction is legal only when `insn[31:26]` equals 19 and `insn[10:3]` equals 8'h3A. A valid illegal word raises `illegal` for the next cycle, does not raise `wb_en`, and leaves `cr_q` unchanged.
- R3: The word uses big-endian numbering: `insn[25:21]` is the register index, also shown on `rs_idx`. `insn[20]` selects the direction (0 gathers a field into an integer, 1 scatters into a field). Mask bit i is `insn[19-i]`, and the field number is `insn[15:13]`.
- R4: In the gather direction, the cycle after a valid legal word has `wb_en` high, `wb_idx` set to the register index, bit 0 of `wb_data` equal to the OR over i of mask[i] AND (mode[i] == field[i]), and all other bits clear. `cr_q` does not change.
- R5: The mode bits are formed as follows: mode[0] is `insn[12]`, mode[1] is `insn[11]`, mode[2] is `insn[2]`, and mode[3] is `insn[1]`.
- R6: Field number b covers bits `cr_q[31-4b]` (field bit 0) down to `cr_q[28-4b]` (field bit 3).
- R7: In the scatter direction, field bit i of the selected field becomes mask[i] AND (mode[i] == s). Here s is `ra_val[0]`, or 0 when the register index is 0. No write-back is raised.
- R8: A scatter leaves the other seven fields of `cr_q` unchanged.
- R9: A zero mask gives a gather result of 0 and clears the whole field on a scatter.
- R10: With `valid` low, `cr_q` holds, and `wb_en` and `illegal` are low on the next cycle.
- R11: Bit `insn[0]` is reserved and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Integer operand read at `rs_idx` |
| rs_idx | output | 5 | Decoded register index for the operand read |
| wb_en | output | 1 | Integer write-back enable |
| wb_idx | output | 5 | Integer write-back index |
| wb_data | output | 64 | Integer write-back value |
| illegal | output | 1 | Previous valid word was not recognised |
| cr_q | output | 32 | Condition register contents |

## Verification
All condition state lives in `cr_q`, which the bench compares with its model on every clock. A wrong field bit therefore shows up on the very next cycle after the faulty scatter, and it does not wait for a later gather to read it. A fault in the gather path or the decode appears on `wb_en`, `wb_data` or `illegal` one cycle after the word. Directed cases cover each field boundary, the index-zero operand and a zero mask. Random words, including corrupted opcodes and keys, then mix all paths.

// File: rtl/cr_pred_unit.sv
module cr_pred_unit #(
  parameter int XLEN   = 64,
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  parameter int OPCODE = 19,
  parameter logic [7:0] XO_KEY = 8'h3A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] ra_val,
  output logic [4:0]      rs_idx,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal,
  output logic [NFIELD*FW-1:0] cr_q
);
  localparam int CRW = NFIELD * FW;

  logic [5:0]    opc;
  logic [4:0]    idx;
  logic          to_cr;
  logic [2:0]    bb;
  logic [7:0]    key;
  logic [3:0]    mode;
  logic [FW-1:0] mask, fld, term;
  logic [CRW-1:0] cr_new, fsel;
  logic          src, legal, red;
  logic          unused_bits;

  assign opc   = insn[31:26];
  assign idx   = insn[25:21];
  assign to_cr = insn[20];
  assign bb    = insn[15:13];
  assign key   = insn[10:3];
  assign mode  = {insn[1], insn[2], insn[11], insn[12]};
  assign legal = (opc == 6'(OPCODE)) && (key == XO_KEY);
  assign src   = (idx != 5'd0) & ra_val[0];
  assign rs_idx = idx;
  assign unused_bits = ^{insn[0], ra_val[XLEN-1:1]};

  always_comb begin
    mask   = '0;
    fld    = '0;
    term   = '0;
    fsel   = '0;
    cr_new = cr_q;
    for (int i = 0; i < FW; i++) begin
      mask[i] = insn[19-i];
      fld[i]  = cr_q[CRW-1-FW*int'(bb)-i];
      term[i] = mask[i] & ~(mode[i] ^ (to_cr ? src : fld[i]));
      cr_new[CRW-1-FW*int'(bb)-i] = term[i];
      fsel[CRW-1-FW*int'(bb)-i]   = 1'b1;
    end
  end

  assign red = |term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q    <= '0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      illegal <= 1'b0;
    end else begin
      wb_en   <= valid & legal & ~to_cr;
      illegal <= valid & ~legal;
      if (valid && legal && !to_cr) begin
        wb_idx  <= idx;
        wb_data <= {{(XLEN-1){1'b0}}, red};
      end
      if (valid && legal && to_cr)
        cr_q <= cr_new;
    end
  end

  // R2
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);

  // R2
  illegal_cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !legal) |=> $stable(cr_q));

  // R4
  gather_cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && legal && !to_cr) |=> $stable(cr_q));

  // R4
  wb_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[XLEN-1:1] == '0));

  // R8
  other_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && legal && to_cr) |=> (((cr_q ^ $past(cr_q)) & ~$past(fsel)) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(cr_q) && !wb_en && !illegal));
endmodule

// File: tb/tb_cr_pred_unit.sv
module tb_cr_pred_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] ra_val = '0;
  logic [4:0]  rs_idx, wb_idx;
  logic        wb_en, illegal;
  logic [63:0] wb_data;
  logic [31:0] cr_q;

  cr_pred_unit dut (.clk(clk), .rst_n(rst_n), .valid(valid), .insn(insn), .ra_val(ra_val),
    .rs_idx(rs_idx), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal(illegal), .cr_q(cr_q));

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;
  string cur_tag = "R1", out_tag = "R1";
  logic [31:0] m_cr;
  logic        m_wb, m_ill;
  logic [4:0]  m_idx;
  logic [63:0] m_data;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [5:0] opc, logic [4:0] idx, bit dir,
      logic [3:0] mk, logic [2:0] bb, logic [3:0] md, logic [7:0] key, bit rsv);
    return {opc, idx, dir, mk[0], mk[1], mk[2], mk[3], bb, md[0], md[1], key, md[2], md[3], rsv};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cr = '0; m_wb = 0; m_ill = 0; m_idx = '0; m_data = '0;
    end else begin
      int opc, ix, dir, bb, key, res, s, p;
      int mk[4], md[4];
      opc = int'(insn >> 26); ix = int'((insn >> 21) % 32); dir = int'((insn >> 20) % 2);
      bb = int'((insn >> 13) % 8); key = int'((insn >> 3) % 256);
      for (int i = 0; i < 4; i++) mk[i] = int'((insn >> (19 - i)) % 2);
      md[0] = int'((insn >> 12) % 2); md[1] = int'((insn >> 11) % 2);
      md[2] = int'((insn >> 2) % 2);  md[3] = int'((insn >> 1) % 2);
      m_wb = 0; m_ill = 0;
      if (valid) begin
        if (opc != 19 || key != 58) m_ill = 1;
        else if (dir == 0) begin
          res = 0;
          for (int i = 0; i < 4; i++) begin
            p = 31 - 4 * bb - i;
            if (mk[i] == 1 && md[i] == int'(m_cr[p])) res = 1;
          end
          m_wb = 1; m_idx = 5'(ix); m_data = 64'(res);
        end else begin
          s = (ix == 0) ? 0 : int'(ra_val[0]);
          for (int i = 0; i < 4; i++) begin
            p = 31 - 4 * bb - i;
            m_cr[p] = (mk[i] == 1 && md[i] == s);
          end
        end
      end
      out_tag = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(out_tag, "cr_q", 64'(cr_q), 64'(m_cr));
      chk(out_tag, "wb_en", 64'(wb_en), 64'(m_wb));
      chk(out_tag, "illegal", 64'(illegal), 64'(m_ill));
      if (m_wb) begin
        chk(out_tag, "wb_idx", 64'(wb_idx), 64'(m_idx));
        chk(out_tag, "wb_data", wb_data, m_data);
      end
    end
  end

  task automatic issue(bit v, logic [31:0] w, logic [63:0] rv, string tag);
    @(negedge clk);
    valid = v; insn = w; ra_val = rv; cur_tag = tag;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "cr_q", 64'(cr_q), 64'd0);
    chk("R1", "wb_en", 64'(wb_en), 64'd0);
    chk("R1", "illegal", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    cmp_on = 1;
    // R7 scatter pattern into field 0 with operand bit 1
    issue(1, enc(19, 3, 1, 4'b1111, 0, 4'b1010, 8'h3A, 0), 64'h1, "R7");
    // R3 rs_idx shows decoded index
    @(posedge clk); #1 chk("R3", "rs_idx", 64'(rs_idx), 64'd3);
    // R6 field 7 with operand bit 0
    issue(1, enc(19, 4, 1, 4'b1111, 7, 4'b0110, 8'h3A, 0), 64'h2, "R6");
    // R8 partial mask into field 3
    issue(1, enc(19, 5, 1, 4'b0101, 3, 4'b1111, 8'h3A, 0), 64'h1, "R8");
    // R4 gather with full mismatch, then R5 partial match
    issue(1, enc(19, 9, 0, 4'b1111, 0, 4'b0101, 8'h3A, 0), 64'h0, "R4");
    issue(1, enc(19, 10, 0, 4'b1111, 0, 4'b1000, 8'h3A, 0), 64'h0, "R5");
    issue(1, enc(19, 11, 0, 4'b1000, 3, 4'b1000, 8'h3A, 0), 64'h0, "R5");
    // R3 gather from field 7 to index 31
    issue(1, enc(19, 31, 0, 4'b0010, 7, 4'b0000, 8'h3A, 0), 64'h0, "R3");
    // R9 zero mask
    issue(1, enc(19, 12, 0, 4'b0000, 7, 4'b1001, 8'h3A, 0), 64'h0, "R9");
    issue(1, enc(19, 12, 1, 4'b0000, 7, 4'b1111, 8'h3A, 0), 64'h1, "R9");
    // R7 index zero forces operand 0
    issue(1, enc(19, 0, 1, 4'b1111, 1, 4'b1111, 8'h3A, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    issue(1, enc(19, 0, 1, 4'b1111, 2, 4'b0000, 8'h3A, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    // R2 bad opcode and bad key
    issue(1, enc(18, 6, 1, 4'b1111, 0, 4'b0000, 8'h3A, 0), 64'h1, "R2");
    issue(1, enc(19, 6, 1, 4'b1111, 0, 4'b0000, 8'h3B, 0), 64'h1, "R2");
    issue(1, enc(19, 6, 0, 4'b1111, 0, 4'b1111, 8'h00, 0), 64'h1, "R2");
    // R11 reserved bit set
    issue(1, enc(19, 7, 0, 4'b1111, 2, 4'b1111, 8'h3A, 1), 64'h0, "R11");
    issue(1, enc(19, 7, 1, 4'b1100, 4, 4'b1111, 8'h3A, 1), 64'h1, "R11");
    // R10 no strobe
    issue(0, enc(19, 8, 1, 4'b1111, 4, 4'b0000, 8'h3A, 0), 64'h1, "R10");
    issue(0, enc(19, 8, 0, 4'b1111, 4, 4'b0000, 8'h3A, 0), 64'h1, "R10");
    for (int k = 0; k < 400; k++) begin
      logic [5:0] opc; logic [7:0] key; bit v, dir; string tg;
      opc = ($urandom % 8 == 0) ? 6'($urandom) : 6'd19;
      key = ($urandom % 8 == 0) ? 8'($urandom) : 8'h3A;
      v = ($urandom % 6) != 0;
      dir = 1'($urandom);
      if (!v) tg = "R10";
      else if (opc != 19 || key != 8'h3A) tg = "R2";
      else if (dir) tg = "R7";
      else tg = "R4";
      issue(v, enc(opc, 5'($urandom), dir, 4'($urandom), 3'($urandom), 4'($urandom), key,
        1'($urandom)), {$urandom, $urandom}, tg);
    end
    issue(0, '0, '0, "R10");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule